// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks one prefixed vector instruction through its elements, one operation at a time. After a start pulse it steps an element index upward from zero and, inside each element, a sub-element index. For every element it decides from a single predicate source whether the element is enabled. The source is either a bit pattern held in one of three integer registers or a bit of a condition-register field. Enabled elements are issued as normal operations. Masked-off elements are either issued as zero writes or skipped, depending on the zeroing bit.

Two modes depend on a per-element test result that the execution unit returns after the element's last sub-element. In fail-first mode, a failing test cuts the vector length short at that element. In predicate-result mode, a failing test cancels the element's result write but keeps its condition write. The arithmetic, saturation, reduction and register access are done elsewhere. The integer register values and the condition bits arrive as snapshots and must stay stable while the block is busy. The control fields are captured at start.

Top module: `vec_elem_seq`

## Requirements
- R1: A start with VL = 0 issues nothing and raises `done` in the cycle after the start edge, with `final_vl` = 0.
- R2: Elements are issued in ascending order. For each enabled element, sub-elements 0 up to the SUBVL code (00→1, 01→2, 10→3, 11→4 sub-elements) are issued in order before the next element.
- R3: With `mask_kind` = 0, element i is enabled by `mask_code` as follows. 000 always. 001 when R3 equals i. 010/011 when bit i of R3 is set/clear. 100/101 the same tests on R10. 110/111 the same tests on R30.
- R4: With `mask_kind` = 1, field i is `cr_vec[4i+3:4i]` with LT at bit 3, GT at bit 2, EQ at bit 1 and SO at bit 0. `mask_code[2:1]` picks LT/GT/EQ/SO (00/01/10/11), and `mask_code[0]` = 1 enables on a clear bit.
- R5: Only the source selected by `mask_kind` affects enables. Condition bits do not matter for the integer kind, and register values do not matter for the condition kind.
- R6: A masked-off element is issued with `iss_zero` = 1, `iss_wen` = 1 and `iss_crwen` = 0 on every sub-element when `zero_en` = 1. It is skipped with no issue when `zero_en` = 0.
- R7: `mode_sel` 00 (normal) and 10 (saturate) sequence identically. Enabled issues carry `iss_wen` = 1 and `iss_crwen` = `rc_en`. No test result is awaited, and the run ends with `final_vl` = VL.
- R8: `mode_sel` 01 (fail-first) awaits a test after each enabled element. The test passes when `res_cr` bit chosen by `test_sel` (same encoding as R4) XOR `test_inv` is 1. A fail at element i commits that element with write disabled, ends the run with `final_vl` = i, and issues nothing after it.
- R9: `mode_sel` 11 (predicate-result) awaits a test after each enabled element. The commit carries `commit_wen` = pass and `commit_crwen` = `rc_en`, and the run always continues to VL.
- R10: An issue is held with a stable index until `iss_ready`. In test modes, enabled issues carry `iss_wen` = `iss_crwen` = 0, and no further element is issued until `res_valid` arrives. Nothing is issued or committed while idle.
- R11: A start pulse while busy is ignored, even when `vl_in` has changed.
- R12: VL up to 64 is supported. A larger `vl_in` is clamped to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin sequencing when idle |
| vl_in | input | 7 | Vector length |
| subvl_in | input | 2 | Sub-element count code |
| mask_kind | input | 1 | 0 integer, 1 condition predicate |
| mask_code | input | 3 | Predicate selector |
| zero_en | input | 1 | Zero masked elements instead of skipping |
| mode_sel | input | 2 | Mode select |
| test_inv | input | 1 | Invert the result test |
| test_sel | input | 2 | Result bit tested |
| rc_en | input | 1 | Condition result written |
| r3_val | input | 64 | Integer register snapshot 3 |
| r10_val | input | 64 | Integer register snapshot 10 |
| r30_val | input | 64 | Integer register snapshot 30 |
| cr_vec | input | 256 | Condition fields for elements 0..63 |
| iss_ready | input | 1 | Issue accepted |
| res_valid | input | 1 | Test result present |
| res_cr | input | 4 | Result condition field |
| busy | output | 1 | Run in progress |
| iss_valid | output | 1 | Issue offered |
| elem_idx | output | 6 | Element index |
| sub_idx | output | 2 | Sub-element index |
| iss_zero | output | 1 | Issue writes zero |
| iss_wen | output | 1 | Result write at issue |
| iss_crwen | output | 1 | Condition write at issue |
| commit_valid | output | 1 | Test result consumed |
| commit_wen | output | 1 | Deferred result write |
| commit_crwen | output | 1 | Deferred condition write |
| done | output | 1 | One-cycle end pulse |
| final_vl | output | 7 | Resulting vector length |

## Verification
Every cycle, the assertions check several properties. An offered issue holds steady while stalled, and its element and sub-element indices stay below the captured VL and SUBVL. An idle block neither issues nor commits. A zero VL finishes at once, and the final length never exceeds the captured VL. The scenarios then compare whole issue and commit traces against a model built from the requirements. These traces show what no single-cycle property can: which elements each predicate code selects, whether masked elements are zeroed or skipped, where fail-first truncates, and how predicate-result splits the result and condition writes.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'b00,
        MD_FFIRST = 2'b01,
        MD_SAT    = 2'b10,
        MD_PRES   = 2'b11
    } vmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_WAIT = 2'b10
    } seq_st_e;

    // Bit positions inside a 4-bit condition field
    localparam int CRB_LT = 3;
    localparam int CRB_GT = 2;
    localparam int CRB_EQ = 1;
    localparam int CRB_SO = 0;

    function automatic logic cr_pick(input logic [3:0] fld, input logic [1:0] sel);
        logic b;
        case (sel)
            2'b00:   b = fld[CRB_LT];
            2'b01:   b = fld[CRB_GT];
            2'b10:   b = fld[CRB_EQ];
            default: b = fld[CRB_SO];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vseq_pred.sv
module vseq_pred
    import vseq_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int XLEN  = 64,
    parameter int IW    = 6
) (
    input  logic [IW-1:0]      idx,
    input  logic               kind,
    input  logic [2:0]         code,
    input  logic [XLEN-1:0]    r3_val,
    input  logic [XLEN-1:0]    r10_val,
    input  logic [XLEN-1:0]    r30_val,
    input  logic [4*MAXVL-1:0] cr_vec,
    output logic               en
);
    logic [XLEN-1:0] src;
    logic [3:0]      fld;
    logic            int_en;
    logic            cr_en;

    always_comb begin
        case (code[2:1])
            2'b00, 2'b01: src = r3_val;
            2'b10:        src = r10_val;
            default:      src = r30_val;
        endcase
        if (code == 3'b000) begin
            int_en = 1'b1;
        end else if (code == 3'b001) begin
            int_en = (r3_val == XLEN'(idx));
        end else begin
            int_en = src[idx] ^ code[0];
        end
        fld   = cr_vec[4*int'(idx) +: 4];
        cr_en = cr_pick(fld, code[2:1]) ^ code[0];
        en    = kind ? cr_en : int_en;
    end
endmodule

// File: rtl/vseq_rtest.sv
module vseq_rtest
    import vseq_pkg::*;
(
    input  logic [3:0] res_cr,
    input  logic [1:0] sel,
    input  logic       inv,
    output logic       pass
);
    assign pass = cr_pick(res_cr, sel) ^ inv;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int XLEN  = 64,
    localparam int IW   = $clog2(MAXVL),
    localparam int VW   = $clog2(MAXVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VW-1:0]      vl_in,
    input  logic [1:0]         subvl_in,
    input  logic               mask_kind,
    input  logic [2:0]         mask_code,
    input  logic               zero_en,
    input  logic [1:0]         mode_sel,
    input  logic               test_inv,
    input  logic [1:0]         test_sel,
    input  logic               rc_en,
    input  logic [XLEN-1:0]    r3_val,
    input  logic [XLEN-1:0]    r10_val,
    input  logic [XLEN-1:0]    r30_val,
    input  logic [4*MAXVL-1:0] cr_vec,
    input  logic               iss_ready,
    input  logic               res_valid,
    input  logic [3:0]         res_cr,
    output logic               busy,
    output logic               iss_valid,
    output logic [IW-1:0]      elem_idx,
    output logic [1:0]         sub_idx,
    output logic               iss_zero,
    output logic               iss_wen,
    output logic               iss_crwen,
    output logic               commit_valid,
    output logic               commit_wen,
    output logic               commit_crwen,
    output logic               done,
    output logic [VW-1:0]      final_vl
);
    typedef struct packed {
        seq_st_e       st;
        logic [IW-1:0] elem;
        logic [1:0]    sub;
        logic [VW-1:0] vl;
        logic [1:0]    subvl;
        logic          kind;
        logic [2:0]    code;
        logic          zen;
        vmode_e        mode;
        logic          inv;
        logic [1:0]    tsel;
        logic          rc;
        logic          done;
        logic [VW-1:0] fvl;
    } seq_t;

    seq_t q, d;

    logic elem_en;
    logic test_pass;
    logic test_mode;
    logic issue_ok;
    logic last_elem;
    logic step;

    vseq_pred #(.MAXVL(MAXVL), .XLEN(XLEN), .IW(IW)) u_pred (
        .idx     (q.elem),
        .kind    (q.kind),
        .code    (q.code),
        .r3_val  (r3_val),
        .r10_val (r10_val),
        .r30_val (r30_val),
        .cr_vec  (cr_vec),
        .en      (elem_en)
    );

    vseq_rtest u_rtest (
        .res_cr (res_cr),
        .sel    (q.tsel),
        .inv    (q.inv),
        .pass   (test_pass)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        step      = 1'b0;
        test_mode = (q.mode == MD_FFIRST) || (q.mode == MD_PRES);
        issue_ok  = elem_en || q.zen;
        last_elem = (VW'(q.elem) == q.vl - VW'(1));

        iss_valid    = (q.st == ST_RUN) && issue_ok;
        iss_zero     = !elem_en;
        iss_wen      = !elem_en || !test_mode;
        iss_crwen    = elem_en && !test_mode && q.rc;
        commit_valid = (q.st == ST_WAIT) && res_valid;
        commit_wen   = test_pass;
        commit_crwen = q.rc;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.vl    = (vl_in > VW'(MAXVL)) ? VW'(MAXVL) : vl_in;
                    d.subvl = subvl_in;
                    d.kind  = mask_kind;
                    d.code  = mask_code;
                    d.zen   = zero_en;
                    d.mode  = vmode_e'(mode_sel);
                    d.inv   = test_inv;
                    d.tsel  = test_sel;
                    d.rc    = rc_en;
                    d.elem  = '0;
                    d.sub   = '0;
                    if (vl_in == '0) begin
                        d.done = 1'b1;
                        d.fvl  = '0;
                    end else begin
                        d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!issue_ok) begin
                    step = 1'b1;
                end else if (iss_ready) begin
                    if (q.sub != q.subvl) begin
                        d.sub = q.sub + 2'd1;
                    end else begin
                        d.sub = '0;
                        if (elem_en && test_mode) begin
                            d.st = ST_WAIT;
                        end else begin
                            step = 1'b1;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (res_valid) begin
                    if (q.mode == MD_FFIRST && !test_pass) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.fvl  = VW'(q.elem);
                    end else begin
                        d.st = ST_RUN;
                        step = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (step) begin
            if (last_elem) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                d.fvl  = q.vl;
            end else begin
                d.elem = q.elem + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.mode <= MD_NORMAL;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign elem_idx = q.elem;
    assign sub_idx  = q.sub;
    assign done     = q.done;
    assign final_vl = q.fvl;
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
    parameter int MAXVL = 64,
    localparam int IW   = $clog2(MAXVL),
    localparam int VW   = $clog2(MAXVL + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic [VW-1:0] vl_in,
    input logic [1:0]    subvl_in,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [IW-1:0] elem_idx,
    input logic [1:0]    sub_idx,
    input logic          commit_valid,
    input logic          done,
    input logic [VW-1:0] final_vl
);
    logic [VW-1:0] cap_vl;
    logic [1:0]    cap_sv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vl <= '0;
            cap_sv <= '0;
        end else if (start && !busy) begin
            cap_vl <= (vl_in > VW'(MAXVL)) ? VW'(MAXVL) : vl_in;
            cap_sv <= subvl_in;
        end
    end

    a_r1_zero_vl_done: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && vl_in == '0 |=> done && final_vl == '0 && !iss_valid);

    a_r2_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> sub_idx <= cap_sv);

    a_r12_elem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> VW'(elem_idx) < cap_vl);

    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready |=> iss_valid && $stable(elem_idx) && $stable(sub_idx));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !iss_valid && !commit_valid);

    a_r8_final_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> final_vl <= cap_vl);
endmodule

bind vec_elem_seq vseq_chk #(.MAXVL(MAXVL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .vl_in        (vl_in),
    .subvl_in     (subvl_in),
    .iss_valid    (iss_valid),
    .iss_ready    (iss_ready),
    .elem_idx     (elem_idx),
    .sub_idx      (sub_idx),
    .commit_valid (commit_valid),
    .done         (done),
    .final_vl     (final_vl)
);

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;
    localparam int MAXVL = 64;
    localparam int XLEN  = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [6:0]   vl_in = '0;
    logic [1:0]   subvl_in = '0;
    logic         mask_kind = 1'b0;
    logic [2:0]   mask_code = '0;
    logic         zero_en = 1'b0;
    logic [1:0]   mode_sel = '0;
    logic         test_inv = 1'b0;
    logic [1:0]   test_sel = '0;
    logic         rc_en = 1'b0;
    logic [63:0]  r3_val = '0, r10_val = '0, r30_val = '0;
    logic [255:0] cr_vec = '0;
    logic         iss_ready = 1'b1;
    logic         res_valid = 1'b0;
    logic [3:0]   res_cr = '0;
    logic         busy, iss_valid, iss_zero, iss_wen, iss_crwen;
    logic         commit_valid, commit_wen, commit_crwen, done;
    logic [5:0]   elem_idx;
    logic [1:0]   sub_idx;
    logic [6:0]   final_vl;

    vec_elem_seq #(.MAXVL(MAXVL), .XLEN(XLEN)) uut (.*);

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    logic [3:0]  res_field [64];
    logic        rdy_rand = 1'b0;
    logic [10:0] got_i [512];
    logic [10:0] exp_i [512];
    logic [7:0]  got_c [128];
    logic [7:0]  exp_c [128];
    int          n_got_i, n_exp_i, n_got_c, n_exp_c;
    int          exp_fvl;
    logic        pend = 1'b0;
    logic [5:0]  pend_elem = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Ready pattern, test responder and trace monitor
    initial begin
        logic [7:0] lfsr = 8'h5b;
        forever begin
            @(posedge clk);
            #2;
            lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            iss_ready = rdy_rand ? lfsr[0] : 1'b1;
            res_valid = pend;
            res_cr    = res_field[pend_elem];
            pend      = 1'b0;
            @(negedge clk);
            if (iss_valid && iss_ready) begin
                got_i[n_got_i] = {elem_idx, sub_idx, iss_zero, iss_wen, iss_crwen};
                n_got_i++;
                if (mode_sel[0] && !iss_zero && sub_idx == subvl_in) begin
                    pend      = 1'b1;
                    pend_elem = elem_idx;
                end
            end
            if (commit_valid) begin
                got_c[n_got_c] = {elem_idx, commit_wen, commit_crwen};
                n_got_c++;
            end
        end
    end

    initial begin
        #1_500_000;
        n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    function automatic bit p_en(input int i);
        logic [63:0] s;
        if (mask_kind) begin
            return cr_vec[4*i + (3 - int'(mask_code[2:1]))] ^ mask_code[0];
        end
        if (mask_code == 3'd0) return 1'b1;
        if (mask_code == 3'd1) return r3_val == 64'(i);
        s = (mask_code[2:1] == 2'b01) ? r3_val : (mask_code[2:1] == 2'b10) ? r10_val : r30_val;
        return s[i] ^ mask_code[0];
    endfunction

    function automatic bit p_pass(input int i);
        return res_field[i][3 - int'(test_sel)] ^ test_inv;
    endfunction

    task automatic build_exp();
        int  vl = (vl_in > 7'd64) ? 64 : int'(vl_in);
        bit  tm = mode_sel[0];
        n_exp_i = 0;
        n_exp_c = 0;
        exp_fvl = vl;
        for (int i = 0; i < vl; i++) begin
            bit en = p_en(i);
            if (en || zero_en) begin
                for (int s = 0; s <= int'(subvl_in); s++) begin
                    exp_i[n_exp_i] = {6'(i), 2'(s), !en, !en || !tm, en && !tm && rc_en};
                    n_exp_i++;
                end
            end
            if (en && tm) begin
                bit p = p_pass(i);
                exp_c[n_exp_c] = {6'(i), p, rc_en};
                n_exp_c++;
                if (mode_sel == 2'b01 && !p) begin
                    exp_fvl = i;
                    break;
                end
            end
        end
    endtask

    task automatic run_case(input string tag, input bit inject);
        int   cyc = 0;
        logic [6:0] keep;
        build_exp();
        n_got_i = 0;
        n_got_c = 0;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        if (inject) begin
            keep = vl_in;
            repeat (3) @(posedge clk);
            #2 start = 1'b1; vl_in = 7'd3;
            @(posedge clk); #2 start = 1'b0; vl_in = keep;
        end
        while (cyc < 3000) begin
            @(negedge clk);
            if (done) break;
            cyc++;
        end
        chk(done, tag, "done seen", int'(done), 1);
        chk(int'(final_vl) == exp_fvl, tag, "final_vl", int'(final_vl), exp_fvl);
        chk(n_got_i == n_exp_i, tag, "issue count", n_got_i, n_exp_i);
        begin
            int bad = -1;
            for (int k = 0; k < n_exp_i && k < n_got_i; k++)
                if (bad < 0 && got_i[k] !== exp_i[k]) bad = k;
            chk(bad < 0, tag, "issue trace entry",
                bad < 0 ? 0 : int'(got_i[bad]), bad < 0 ? 0 : int'(exp_i[bad]));
        end
        chk(n_got_c == n_exp_c, tag, "commit count", n_got_c, n_exp_c);
        begin
            int bad = -1;
            for (int k = 0; k < n_exp_c && k < n_got_c; k++)
                if (bad < 0 && got_c[k] !== exp_c[k]) bad = k;
            chk(bad < 0, tag, "commit trace entry",
                bad < 0 ? 0 : int'(got_c[bad]), bad < 0 ? 0 : int'(exp_c[bad]));
        end
        repeat (2) @(posedge clk);
        #2;
    endtask

    task automatic defaults();
        subvl_in = 0; mask_kind = 0; mask_code = 0; zero_en = 0; mode_sel = 0;
        test_inv = 0; test_sel = 0; rc_en = 0; rdy_rand = 0;
        r3_val = 64'hA5A5_0F0F_3C3C_9669;
        r10_val = 64'h1234_5678_9ABC_DEF0;
        r30_val = 64'hF0F0_0FF0_C3C3_7E81;
        cr_vec = {64'h9E37_79B9_7F4A_7C15, 64'hBF58_476D_1CE4_E5B9,
                  64'h94D0_49BB_1331_11EB, 64'h2545_F491_4F6C_DD1D};
        for (int i = 0; i < 64; i++) res_field[i] = 4'b0010;
    endtask

    task automatic t_reset();
        chk(!busy && !iss_valid && !done && !commit_valid, "R10", "idle after reset",
            int'({busy, iss_valid, done, commit_valid}), 0);
    endtask

    task automatic t_zero_vl();
        defaults(); vl_in = 0; rdy_rand = 1;
        n_got_i = 0;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        @(negedge clk);
        chk(done && final_vl == 0, "R1", "immediate done with VL 0", int'(done), 1);
        chk(n_got_i == 0, "R1", "no issue with VL 0", n_got_i, 0);
        repeat (2) @(posedge clk); #2;
    endtask

    task automatic t_subvl();
        defaults(); vl_in = 5; subvl_in = 2'b10; rdy_rand = 1;
        run_case("R2", 0);
        subvl_in = 2'b11; vl_in = 3;
        run_case("R2", 0);
    endtask

    task automatic t_int_mask();
        defaults(); rdy_rand = 1; vl_in = 20;
        for (int c = 1; c < 8; c++) begin
            mask_code = 3'(c);
            r3_val = (c == 1) ? 64'd7 : 64'hA5A5_0F0F_3C3C_9669;
            run_case("R3", 0);
        end
    endtask

    task automatic t_cr_mask();
        defaults(); mask_kind = 1; vl_in = 16;
        for (int c = 0; c < 8; c++) begin
            mask_code = 3'(c);
            run_case("R4", 0);
        end
    endtask

    task automatic t_exclusive();
        defaults(); vl_in = 9; mask_kind = 0; mask_code = 0;
        run_case("R5", 0);
        mask_kind = 1; mask_code = 3'b011;
        r3_val = '1; r10_val = '1; r30_val = '1;
        run_case("R5", 0);
    endtask

    task automatic t_zeroing();
        defaults(); vl_in = 12; subvl_in = 2'b01; mask_code = 3'b010; zero_en = 1;
        run_case("R6", 0);
        zero_en = 0;
        run_case("R6", 0);
    endtask

    task automatic t_sat();
        defaults(); vl_in = 7; subvl_in = 2'b11; mask_code = 3'b100; mode_sel = 2'b10;
        rc_en = 1; rdy_rand = 1;
        run_case("R7", 0);
        mode_sel = 2'b00;
        run_case("R7", 0);
    endtask

    task automatic t_ffirst();
        defaults(); vl_in = 10; mode_sel = 2'b01; test_sel = 2'b10; rdy_rand = 1;
        res_field[4] = 4'b0000;
        run_case("R8", 0);
        res_field[0] = 4'b0000; res_field[4] = 4'b0010;
        run_case("R8", 0);
        for (int i = 0; i < 64; i++) res_field[i] = 4'b0000;
        test_inv = 1; subvl_in = 2'b01; mask_code = 3'b101;
        run_case("R10", 0);
    endtask

    task automatic t_predres();
        defaults(); vl_in = 8; mode_sel = 2'b11; rc_en = 1; subvl_in = 2'b01;
        test_sel = 2'b00;
        for (int i = 0; i < 64; i++) res_field[i] = (i % 3 == 0) ? 4'b1000 : 4'b0111;
        run_case("R9", 0);
        zero_en = 1; mask_code = 3'b011; rdy_rand = 1;
        run_case("R9", 0);
    endtask

    task automatic t_busy_start();
        defaults(); vl_in = 6; subvl_in = 2'b01;
        run_case("R11", 1);
    endtask

    task automatic t_long();
        defaults(); vl_in = 64; mask_code = 3'b111; subvl_in = 2'b01;
        run_case("R12", 0);
        vl_in = 7'd100; mask_code = 3'b000; subvl_in = 2'b00;
        run_case("R12", 0);
    endtask

    initial begin
        defaults();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(posedge clk); #2;
        t_zero_vl();
        t_subvl();
        t_int_mask();
        t_cr_mask();
        t_exclusive();
        t_zeroing();
        t_sat();
        t_ffirst();
        t_predres();
        t_busy_start();
        t_long();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule